// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Decade Counter

This block counts events with a five-stage twisted-ring (Johnson) register that walks through ten legal codes. Each code is decoded into one of ten one-hot outputs, and an active-low carry taken from the last ring stage lets a second counter be chained. Two control inputs can each cause a step. A rising edge on `step_rise_in` counts while `step_fall_in` is low. A falling edge on `step_fall_in` counts while `step_rise_in` is high. Both inputs are oversampled by one system clock, so the counting logic stays synchronous.

An active-high master reset, `mr`, forces the count to zero as soon as it rises and overrides both step inputs. Its release is resynchronized to the system clock. A feedback term inside the ring folds any illegal code back into the ten-state loop. A synchronous preset port can write any raw pattern into the ring, and this is how illegal codes are injected.

Top module: `tr_decade_counter`

## Requirements
- R1: Ring code r[4:0] (r[0] is the first stage) for count k is the low k bits set for k ≤ 5, and for k from 6 to 9 it is 11111 shifted left by k−5 and truncated to 5 bits. For count k, output `q` equals 1 << k: exactly one bit set. Each step moves k to (k+1) mod 10.
- R2: A rising edge on `step_rise_in` while `step_fall_in` is low advances the count by one.
- R3: A falling edge on `step_fall_in` while `step_rise_in` is high advances the count by one.
- R4: A rising edge on `step_rise_in` while `step_fall_in` is high, and a falling edge on `step_fall_in` while `step_rise_in` is low, leave the count unchanged.
- R5: `carry_n` is low for counts 5 to 9 and high for counts 0 to 4.
- R6: While `mr` is high, `q` is 1 and `carry_n` is high. This takes effect without waiting for a clock edge, and no step input changes it.
- R7: From any of the 22 illegal ring codes, the ring reaches a legal code within 11 advances and then follows the R1 sequence.
- R8: When a rising edge on `step_rise_in` and a falling edge on `step_fall_in` qualify in the same sampled cycle, the count advances exactly once.
- R9: When `preset_en` is high at a clock edge, `preset_ring` (bit 0 = first stage) is written into the ring. A legal code then decodes as in R1, and an illegal code decodes to more than one set bit of `q`.
- R10: A qualifying step-input edge applied between clock edges changes `q` at the third rising clock edge. The ring stays at count 0 for two clock edges after `mr` falls, and an edge that arrives while `mr` is high is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the step inputs |
| mr | input | 1 | Master reset, active high. Asserts immediately; release is synchronized |
| step_rise_in | input | 1 | Step control counted on its rising edge |
| step_fall_in | input | 1 | Step control counted on its falling edge |
| preset_en | input | 1 | Synchronous write of `preset_ring` into the ring |
| preset_ring | input | 5 | Raw ring pattern to write |
| q | output | 10 | One-hot decoded count |
| carry_n | output | 1 | Active-low carry: low for counts 5 to 9 |

## Verification
The assertions take for granted that the step inputs hold each level for at least three system-clock cycles. Shorter levels would let the synchronizer drop or merge edges, and the step properties would then describe an input sequence the block never saw. The stimulus holds every level for four cycles. It changes inputs only on falling clock edges, and it raises `preset_en` for exactly one cycle while both step inputs are quiet. As a result, a preset never coincides with an advance pulse.

// File: rtl/tr_decade_pkg.sv
package tr_decade_pkg;

  localparam int unsigned DEF_STAGES = 5;
  localparam int unsigned DEF_SYNC   = 2;

  function automatic logic [DEF_STAGES-1:0] legal_code(input int unsigned k);
    logic [DEF_STAGES-1:0] all_ones;
    all_ones = '1;
    if (k <= DEF_STAGES) legal_code = all_ones >> (DEF_STAGES - k);
    else                 legal_code = all_ones << (k - DEF_STAGES);
  endfunction

endpackage

// File: rtl/tr_step_qualifier.sv
module tr_step_qualifier #(
  parameter int unsigned SYNC = tr_decade_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rise_in,
  input  logic fall_in,
  output logic adv
);
  localparam int unsigned DEPTH = SYNC + 1;

  logic [DEPTH-1:0] rise_sh;
  logic [DEPTH-1:0] fall_sh;

  always_ff @(posedge clk) begin
    rise_sh <= {rise_sh[DEPTH-2:0], rise_in};
    fall_sh <= {fall_sh[DEPTH-2:0], fall_in};
  end

  logic rise_now, rise_old, fall_now, fall_old;
  assign rise_now = rise_sh[SYNC-1];
  assign rise_old = rise_sh[SYNC];
  assign fall_now = fall_sh[SYNC-1];
  assign fall_old = fall_sh[SYNC];

  logic rise_evt, fall_evt;
  assign rise_evt = rise_now & ~rise_old & ~fall_now;
  assign fall_evt = ~fall_now & fall_old & rise_now;

  assign adv = rise_evt | fall_evt;
endmodule

// File: rtl/tr_reset_release.sv
module tr_reset_release #(
  parameter int unsigned SYNC = tr_decade_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic mr,
  output logic hold
);
  logic [SYNC-1:0] sh;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) sh <= '1;
    else    sh <= {sh[SYNC-2:0], 1'b0};
  end

  assign hold = sh[SYNC-1];
endmodule

// File: rtl/tr_johnson_ring.sv
module tr_johnson_ring #(
  parameter int unsigned STAGES = tr_decade_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              mr,
  input  logic              hold,
  input  logic              adv,
  input  logic              load,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] ring
);
  logic [STAGES-1:0] nxt;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign nxt[i] = ~ring[STAGES-1];
      end else if (i == 2) begin : g_fix
        assign nxt[i] = ring[1] & (ring[0] | ring[2]);
      end else begin : g_shift
        assign nxt[i] = ring[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge mr) begin
    if (mr)        ring <= '0;
    else if (hold) ring <= '0;
    else if (load) ring <= load_val;
    else if (adv)  ring <= nxt;
  end
endmodule

// File: rtl/tr_ring_decoder.sv
module tr_ring_decoder #(
  parameter int unsigned STAGES = tr_decade_pkg::DEF_STAGES,
  localparam int unsigned NSTATES = 2 * STAGES
) (
  input  logic [STAGES-1:0]  ring,
  output logic [NSTATES-1:0] q,
  output logic               carry_n
);
  generate
    for (genvar k = 0; k < NSTATES; k++) begin : g_dec
      if (k == 0) begin : g_zero
        assign q[k] = ~ring[STAGES-1] & ~ring[0];
      end else if (k < STAGES) begin : g_fill
        assign q[k] = ring[k-1] & ~ring[k];
      end else if (k == STAGES) begin : g_full
        assign q[k] = ring[STAGES-1] & ring[0];
      end else begin : g_drain
        assign q[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
      end
    end
  endgenerate

  assign carry_n = ~ring[STAGES-1];
endmodule

// File: rtl/tr_decade_counter.sv
module tr_decade_counter #(
  parameter int unsigned STAGES = tr_decade_pkg::DEF_STAGES,
  parameter int unsigned SYNC   = tr_decade_pkg::DEF_SYNC,
  localparam int unsigned NSTATES = 2 * STAGES
) (
  input  logic               clk,
  input  logic               mr,
  input  logic               step_rise_in,
  input  logic               step_fall_in,
  input  logic               preset_en,
  input  logic [STAGES-1:0]  preset_ring,
  output logic [NSTATES-1:0] q,
  output logic               carry_n
);
  logic adv;
  logic rst_hold;
  logic [STAGES-1:0] ring;

  tr_step_qualifier #(.SYNC(SYNC)) u_qual (
    .clk(clk), .rise_in(step_rise_in), .fall_in(step_fall_in), .adv(adv)
  );

  tr_reset_release #(.SYNC(SYNC)) u_rel (
    .clk(clk), .mr(mr), .hold(rst_hold)
  );

  tr_johnson_ring #(.STAGES(STAGES)) u_ring (
    .clk(clk), .mr(mr), .hold(rst_hold), .adv(adv),
    .load(preset_en), .load_val(preset_ring), .ring(ring)
  );

  tr_ring_decoder #(.STAGES(STAGES)) u_dec (
    .ring(ring), .q(q), .carry_n(carry_n)
  );
endmodule

// File: rtl/tr_decade_checker.sv
module tr_decade_checker #(
  parameter int unsigned NSTATES = 10
) (
  input logic               clk,
  input logic               mr,
  input logic               hold,
  input logic               adv,
  input logic               preset_en,
  input logic [NSTATES-1:0] q,
  input logic               carry_n
);
  localparam int unsigned HALF = NSTATES / 2;

  p_step_rotates_r1: assert property (@(posedge clk) disable iff (mr || hold)
    (adv && !preset_en && $onehot(q)) |=> (q == {$past(q[NSTATES-2:0]), $past(q[NSTATES-1])}));

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (mr || hold)
    (!adv && !preset_en) |=> $stable(q));

  p_carry_half_r5: assert property (@(posedge clk) disable iff (mr)
    $onehot(q) |-> (carry_n == ~(|q[NSTATES-1:HALF])));

  p_mr_zero_r6: assert property (@(posedge clk)
    mr |-> (q == NSTATES'(1) && carry_n));

  p_legal_kept_r7: assert property (@(posedge clk) disable iff (mr || hold)
    ($onehot(q) && !preset_en) |=> $onehot(q));

  p_release_zero_r10: assert property (@(posedge clk) disable iff (mr)
    $past(mr) |-> (q == NSTATES'(1)));
endmodule

bind tr_decade_counter tr_decade_checker #(.NSTATES(NSTATES)) u_chk (
  .clk(clk), .mr(mr), .hold(rst_hold), .adv(adv),
  .preset_en(preset_en), .q(q), .carry_n(carry_n)
);

// File: tb/tr_decade_counter_bench.sv
module tr_decade_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int NS = 10;

  logic clk = 1'b0;
  logic mr, rise_in, fall_in, pre_en;
  logic [N-1:0] pre_val;
  logic [NS-1:0] q;
  logic carry_n;

  int checks = 0;
  int errors = 0;
  int count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tr_decade_counter u_tr_decade_counter (
    .clk(clk), .mr(mr), .step_rise_in(rise_in), .step_fall_in(fall_in),
    .preset_en(pre_en), .preset_ring(pre_val), .q(q), .carry_n(carry_n)
  );

  function automatic logic [N-1:0] code_of(input int k);
    logic [N-1:0] ones;
    ones = '1;
    if (k <= N) return ones >> (N - k);
    return ones << (k - N);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_count(input string req);
    chk({req, " q"}, 32'(q), 32'(1) << count);
    chk({req, " carry"}, 32'(carry_n), (count >= 5) ? 32'd0 : 32'd1);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_pulse();
    rise_in = 1'b1; wait_n(4);
    rise_in = 1'b0; wait_n(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mr = 1'b1; rise_in = 1'b0; fall_in = 1'b0; pre_en = 1'b0; pre_val = '0;
    wait_n(3);
    chk("R6 reset q", 32'(q), 32'd1);
    chk("R6 reset carry", 32'(carry_n), 32'd1);
    mr = 1'b0;
    wait_n(4);
    chk_count("R1 after release");

    // R10: step latency of three clock edges
    rise_in = 1'b1;
    wait_n(2);
    chk("R10 no change after two edges", 32'(q), 32'd1);
    wait_n(1);
    count = 1;
    chk_count("R10 change at third edge");
    wait_n(1); rise_in = 1'b0; wait_n(4);

    // R1 R2 R5: long sweep through several wraps
    for (int i = 0; i < 24; i++) begin
      rise_pulse();
      count = (count + 1) % NS;
      chk_count("R2 R1 R5 sweep");
    end

    // R4: rising step edge while fall input high is ignored
    fall_in = 1'b1; wait_n(4);
    chk_count("R4 fall rise ignored");
    rise_in = 1'b1; wait_n(4);
    chk_count("R4 rise while fall high");

    // R3: falling edge on fall input while rise high counts
    for (int i = 0; i < 12; i++) begin
      fall_in = 1'b0; wait_n(4);
      count = (count + 1) % NS;
      chk_count("R3 fall step");
      fall_in = 1'b1; wait_n(4);
      chk_count("R3 fall rising ignored");
    end

    // R4: falling edge on fall input while rise low is ignored
    rise_in = 1'b0; wait_n(4);
    chk_count("R4 rise falling ignored");
    fall_in = 1'b0; wait_n(4);
    chk_count("R4 fall while rise low");

    // R8: both qualify together
    for (int i = 0; i < 3; i++) begin
      fall_in = 1'b1; wait_n(4);
      rise_in = 1'b1; fall_in = 1'b0; wait_n(6);
      count = (count + 1) % NS;
      chk_count("R8 coincident edges");
      rise_in = 1'b0; wait_n(4);
    end

    // R6: asynchronous reset mid-count and overriding steps
    while (count != 7) begin rise_pulse(); count = (count + 1) % NS; end
    chk_count("R5 at seven");
    @(posedge clk); #1; mr = 1'b1; #1;
    chk("R6 async q", 32'(q), 32'd1);
    chk("R6 async carry", 32'(carry_n), 32'd1);
    wait_n(1);
    rise_in = 1'b1; wait_n(5);
    chk("R6 step during reset", 32'(q), 32'd1);
    mr = 1'b0;
    wait_n(1);
    chk("R10 hold after release", 32'(q), 32'd1);
    wait_n(6);
    count = 0;
    chk_count("R10 edge during reset not counted");
    rise_in = 1'b0; wait_n(4);

    // R9: legal presets decode per R1
    for (int k = 0; k < NS; k++) begin
      pre_val = code_of(k); pre_en = 1'b1; wait_n(1); pre_en = 1'b0;
      count = k;
      chk_count("R9 legal preset");
    end

    // R7 R9: every illegal code
    for (int p = 0; p < 32; p++) begin
      bit legal;
      int steps;
      legal = 1'b0;
      for (int k = 0; k < NS; k++) if (code_of(k) == N'(p)) legal = 1'b1;
      if (!legal) begin
        pre_val = N'(p); pre_en = 1'b1; wait_n(1); pre_en = 1'b0;
        chk("R9 illegal decode multi", 32'($countones(q) > 1), 32'd1);
        steps = 0;
        while ($countones(q) != 1 && steps < 12) begin
          rise_pulse();
          steps++;
        end
        chk("R7 recovered within 11", 32'(steps <= 11), 32'd1);
        for (int k = 0; k < NS; k++) if (q == NS'(1) << k) count = k;
        rise_pulse();
        count = (count + 1) % NS;
        chk_count("R7 legal after recovery");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule